// File: doc/BRIEF.md
# Paged auxiliary RAM access router

This block sits between a small 8-bit CPU core and the two places its external-data accesses can land: a 2 KB on-chip auxiliary RAM and an external memory bus. For every read or write strobe it decides the destination, forms the address for that destination and holds the core stalled until the access has used up its cycle budget. The budget is a fixed minimum of two cycles plus zero to three configurable wait states.

An access carries either a full 16-bit pointer address or an 8-bit register-indirect address. An indirect access takes its upper address bits from an 8-bit page register that software writes through a dedicated port. One page register serves every indirect pointer. Page values 00h to 07h pick one of eight 256-byte internal pages. Any larger page value sends the access to the external bus. In that case the external high address byte is left at whatever the last pointer access put there.

A pointer access reaches internal RAM only when three conditions hold: the internal space is enabled, the EEPROM-select bit is clear, and the address lies under a limit set by a 2-bit size field. Every other pointer access goes out with its high byte on the external bus.

Top module: `xram_router`

## Requirements
- R1: After reset the page register is 00h, the external high address byte is 00h, and stall, done, ram_en and ext_req are all low.
- R2: An indirect access (acc_wide=0) with page below 08h goes to internal RAM at address {page[2:0], acc_addr[7:0]} when internal space is enabled and that address is within the size limit.
- R3: An indirect access with page 08h or above goes to the external bus with ext_addr_lo = acc_addr[7:0], and ext_addr_hi keeps its previous value.
- R4: A pointer access (acc_wide=1) goes to internal RAM at acc_addr[10:0] when int_dis=0, eep_sel=0 and acc_addr is at or below the size limit.
- R5: A pointer access that does not go internal drives ext_addr_hi = acc_addr[15:8] and ext_addr_lo = acc_addr[7:0], and ext_addr_hi keeps that value afterwards.
- R6: size_sel encodes the internal size as 00 = 256 B, 01 = 512 B, 10 = 1 KB, 11 = 2 KB. The limit is (256 << size_sel) - 1, and it applies to both access kinds.
- R7: int_dis=1 sends every access external. eep_sel=1 sends every pointer access external.
- R8: After the strobe cycle, stall is high for 1 + wait_cfg cycles and then done is high for exactly one cycle, so an access spans 2 + wait_cfg cycles.
- R9: acc_wr selects a write. ram_we or ext_we is then high with the chosen target's enable, and ram_wdata carries the write data captured at the strobe.
- R10: A page write takes effect at the next clock edge. It never changes an access already started, including one whose strobe falls in the same cycle as the page write.
- R11: Strobes that arrive while an access is in progress are ignored.
- R12: ram_en and ext_req are never high together, and each is high only during an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_wr | input | 1 | Write strobe, one cycle |
| acc_wide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit indirect access |
| acc_addr | input | 16 | Access address (low byte only for indirect) |
| acc_wdata | input | 8 | Write data |
| int_dis | input | 1 | 1 disables the internal space |
| size_sel | input | 2 | Internal size field |
| eep_sel | input | 1 | EEPROM select, blocks internal pointer access |
| wait_cfg | input | 2 | Extra wait states, 0 to 3 |
| page_we | input | 1 | Page register write enable |
| page_wdata | input | 8 | Page register write value |
| ram_addr | output | 11 | Internal RAM address |
| ram_wdata | output | 8 | Internal RAM write data |
| ram_en | output | 1 | Internal RAM enable |
| ram_we | output | 1 | Internal RAM write enable |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External bus write |
| ext_addr_hi | output | 8 | External high address byte |
| ext_addr_lo | output | 8 | External low address byte |
| stall | output | 1 | Core hold while an access runs |
| done | output | 1 | Access completion pulse |

## Verification
Two events can coincide: a page register write and the start of an indirect access. The bench drives page_we and the strobe on the same edge and expects the access to use the old page, and the following access to use the new one. A page write issued in the middle of a running access is also judged at the ports: ram_addr must not move before done, and the next access must show the new page.

// File: rtl/xram_pkg.sv
package xram_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LO_W   = 8;
    localparam int PAGE_W = 8;
    localparam int RAM_AW = 11;
    localparam int SIZE_W = 2;
    localparam int WAIT_W = 2;
    localparam int PSEL_W = RAM_AW - LO_W;

    typedef struct packed {
        logic              to_int;
        logic              load_hi;
        logic [RAM_AW-1:0] ram_addr;
    } route_t;
endpackage

// File: rtl/xram_decode.sv
module xram_decode
    import xram_pkg::*;
(
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  logic              int_dis,
    input  logic              eep_sel,
    input  logic [SIZE_W-1:0] size_sel,
    output route_t            route
);
    localparam int HIGH_PAD = ADDR_W - RAM_AW;

    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] eff_addr;
    logic              page_in;
    logic              in_range;

    always_comb begin
        limit    = ADDR_W'((32'd1 << (LO_W + int'(size_sel))) - 32'd1);
        page_in  = (page[PAGE_W-1:PSEL_W] == '0);
        eff_addr = wide ? addr
                        : {{HIGH_PAD{1'b0}}, page[PSEL_W-1:0], addr[LO_W-1:0]};
        in_range = (eff_addr <= limit);

        route.to_int   = !int_dis && in_range && (wide ? !eep_sel : page_in);
        route.load_hi  = wide && !route.to_int;
        route.ram_addr = eff_addr[RAM_AW-1:0];
    end
endmodule

// File: rtl/xram_timer.sv
module xram_timer
    import xram_pkg::*;
#(
    parameter int MIN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_cfg,
    output logic              busy,
    output logic              done,
    output logic              stall
);
    localparam int CNT_W = $clog2(MIN_CYC + (1 << WAIT_W));

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.busy) begin
            if (start) begin
                t_d.busy = 1'b1;
                t_d.cnt  = CNT_W'(MIN_CYC - 1) + CNT_W'(wait_cfg);
            end
        end else if (t_q.cnt == '0) begin
            t_d.busy = 1'b0;
        end else begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy  = t_q.busy;
    assign done  = t_q.busy && (t_q.cnt == '0);
    assign stall = t_q.busy && (t_q.cnt != '0);

    assert_min_cycles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(stall));
    assert_start_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> stall);
    assert_stall_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));
endmodule

// File: rtl/xram_router.sv
module xram_router
    import xram_pkg::*;
#(
    parameter int MIN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              int_dis,
    input  logic [SIZE_W-1:0] size_sel,
    input  logic              eep_sel,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic              ext_req,
    output logic              ext_we,
    output logic [LO_W-1:0]   ext_addr_hi,
    output logic [LO_W-1:0]   ext_addr_lo,
    output logic              stall,
    output logic              done
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [LO_W-1:0]   hi;
        logic [LO_W-1:0]   lo;
        logic [RAM_AW-1:0] raddr;
        logic [DATA_W-1:0] wdata;
        logic              to_int;
        logic              is_wr;
    } rtr_t;

    rtr_t   s_d, s_q;
    route_t route;
    logic   busy;
    logic   start;

    assign start = !busy && (acc_rd || acc_wr);

    xram_decode u_decode (
        .wide     (acc_wide),
        .addr     (acc_addr),
        .page     (s_q.page),
        .int_dis  (int_dis),
        .eep_sel  (eep_sel),
        .size_sel (size_sel),
        .route    (route)
    );

    xram_timer #(.MIN_CYC(MIN_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wait_cfg (wait_cfg),
        .busy     (busy),
        .done     (done),
        .stall    (stall)
    );

    always_comb begin
        s_d = s_q;
        if (page_we) s_d.page = page_wdata;
        if (start) begin
            s_d.to_int = route.to_int;
            s_d.is_wr  = acc_wr;
            s_d.raddr  = route.ram_addr;
            s_d.lo     = acc_addr[LO_W-1:0];
            s_d.wdata  = acc_wdata;
            if (route.load_hi) s_d.hi = acc_addr[ADDR_W-1:LO_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ram_addr    = s_q.raddr;
    assign ram_wdata   = s_q.wdata;
    assign ram_en      = busy && s_q.to_int;
    assign ram_we      = ram_en && s_q.is_wr;
    assign ext_req     = busy && !s_q.to_int;
    assign ext_we      = ext_req && s_q.is_wr;
    assign ext_addr_hi = s_q.hi;
    assign ext_addr_lo = s_q.lo;

    assert_target_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_en && ext_req));
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall || done) |-> !(ram_en || ext_req));
    assert_hi_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_wide) |=> $stable(ext_addr_hi));
    assert_high_page_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !acc_wide && (s_q.page >= PAGE_W'(1 << PSEL_W))) |=> ext_req);
    assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(ram_addr) && $stable(ext_addr_lo)));
    assert_eep_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && acc_wide && eep_sel) |=> !ram_en);
endmodule

// File: tb/xram_router_bench.sv
module xram_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_rd = 1'b0, acc_wr = 1'b0, acc_wide = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [7:0]  acc_wdata = '0;
    logic        int_dis = 1'b0, eep_sel = 1'b0;
    logic [1:0]  size_sel = 2'b11, wait_cfg = 2'b00;
    logic        page_we = 1'b0;
    logic [7:0]  page_wdata = '0;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata, ext_addr_hi, ext_addr_lo;
    logic        ram_en, ram_we, ext_req, ext_we, stall, done;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    xram_router u_xram_router (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .int_dis(int_dis), .size_sel(size_sel), .eep_sel(eep_sel),
        .wait_cfg(wait_cfg), .page_we(page_we), .page_wdata(page_wdata),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_en(ram_en),
        .ram_we(ram_we), .ext_req(ext_req), .ext_we(ext_we),
        .ext_addr_hi(ext_addr_hi), .ext_addr_lo(ext_addr_lo),
        .stall(stall), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_page(input logic [7:0] v);
        @(negedge clk);
        page_we = 1'b1; page_wdata = v;
        @(negedge clk);
        page_we = 1'b0;
    endtask

    // Runs one access; returns cycles from strobe edge to done and checks target.
    task automatic run(input string req, input logic wr, input logic wide,
                       input logic [15:0] addr, input logic [7:0] wd,
                       input logic exp_int, input int exp_addr,
                       input int exp_hi, input int exp_cyc);
        int n = 1;
        @(negedge clk);
        acc_rd = !wr; acc_wr = wr; acc_wide = wide; acc_addr = addr; acc_wdata = wd;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
        while (!done && n < 20) begin
            if (ram_en && ext_req) chk("R12 both targets", 1, 0);
            @(negedge clk);
            n++;
        end
        chk({req, " cycles R8"}, n, exp_cyc);
        chk({req, " ram_en"}, int'(ram_en), int'(exp_int));
        chk({req, " ext_req"}, int'(ext_req), int'(!exp_int));
        if (exp_int) chk({req, " ram_addr"}, int'(ram_addr), exp_addr);
        else         chk({req, " ext_addr_lo"}, int'(ext_addr_lo), exp_addr & 8'hFF);
        chk({req, " ext_addr_hi"}, int'(ext_addr_hi), exp_hi);
        if (wr) begin
            chk({req, " write enable R9"}, int'(exp_int ? ram_we : ext_we), 1);
            if (exp_int) chk({req, " wdata R9"}, int'(ram_wdata), int'(wd));
        end
        @(negedge clk);
        chk({req, " idle after done R12"}, int'(ram_en | ext_req | stall | done), 0);
    endtask

    task automatic t_reset;
        chk("R1 stall", int'(stall), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ram_en", int'(ram_en), 0);
        chk("R1 ext_req", int'(ext_req), 0);
        chk("R1 ext_addr_hi", int'(ext_addr_hi), 0);
        run("R1 page zero", 1'b0, 1'b0, 16'h0042, 8'h0, 1'b1, 'h042, 0, 2);
    endtask

    task automatic t_narrow;
        set_page(8'h03);
        run("R2 page 3", 1'b0, 1'b0, 16'hAB5A, 8'h0, 1'b1, 'h35A, 0, 2);
        set_page(8'h07);
        run("R2 page 7", 1'b0, 1'b0, 16'h00FF, 8'h0, 1'b1, 'h7FF, 0, 2);
        run("R5 set hi", 1'b0, 1'b1, 16'h1234, 8'h0, 1'b0, 'h34, 'h12, 2);
        set_page(8'h09);
        run("R3 page 09", 1'b0, 1'b0, 16'h5577, 8'h0, 1'b0, 'h77, 'h12, 2);
        set_page(8'hFF);
        run("R3 page FF", 1'b0, 1'b0, 16'h6601, 8'h0, 1'b0, 'h01, 'h12, 2);
        set_page(8'h08);
        run("R3 page 08", 1'b0, 1'b0, 16'h00C3, 8'h0, 1'b0, 'hC3, 'h12, 2);
    endtask

    task automatic t_wide;
        size_sel = 2'b11;
        run("R4 top of ram", 1'b0, 1'b1, 16'h07FF, 8'h0, 1'b1, 'h7FF, 'h12, 2);
        run("R5 just above", 1'b0, 1'b1, 16'h0800, 8'h0, 1'b0, 'h00, 'h08, 2);
        run("R4 bottom", 1'b0, 1'b1, 16'h0000, 8'h0, 1'b1, 'h000, 'h08, 2);
        run("R5 far", 1'b0, 1'b1, 16'hBEEF, 8'h0, 1'b0, 'hEF, 'hBE, 2);
    endtask

    task automatic t_size;
        size_sel = 2'b00;
        run("R6 256 in", 1'b0, 1'b1, 16'h00FF, 8'h0, 1'b1, 'h0FF, 'hBE, 2);
        run("R6 256 out", 1'b0, 1'b1, 16'h0100, 8'h0, 1'b0, 'h00, 'h01, 2);
        size_sel = 2'b01;
        run("R6 512 in", 1'b0, 1'b1, 16'h01FF, 8'h0, 1'b1, 'h1FF, 'h01, 2);
        run("R6 512 out", 1'b0, 1'b1, 16'h0200, 8'h0, 1'b0, 'h00, 'h02, 2);
        size_sel = 2'b10;
        run("R6 1K in", 1'b0, 1'b1, 16'h03FF, 8'h0, 1'b1, 'h3FF, 'h02, 2);
        run("R6 1K out", 1'b0, 1'b1, 16'h0400, 8'h0, 1'b0, 'h00, 'h04, 2);
        size_sel = 2'b00;
        set_page(8'h01);
        run("R6 page beyond size", 1'b0, 1'b0, 16'h0010, 8'h0, 1'b0, 'h10, 'h04, 2);
        size_sel = 2'b11;
    endtask

    task automatic t_ctrl;
        eep_sel = 1'b1;
        run("R7 eep wide", 1'b0, 1'b1, 16'h0123, 8'h0, 1'b0, 'h23, 'h01, 2);
        set_page(8'h02);
        run("R7 eep narrow", 1'b0, 1'b0, 16'h0033, 8'h0, 1'b1, 'h233, 'h01, 2);
        eep_sel = 1'b0;
        int_dis = 1'b1;
        run("R7 dis wide", 1'b0, 1'b1, 16'h0456, 8'h0, 1'b0, 'h56, 'h04, 2);
        run("R7 dis narrow", 1'b0, 1'b0, 16'h0044, 8'h0, 1'b0, 'h44, 'h04, 2);
        int_dis = 1'b0;
    endtask

    task automatic t_wait;
        for (int w = 0; w < 4; w++) begin
            wait_cfg = 2'(w);
            run("R8 wait", 1'b0, 1'b1, 16'h0100, 8'h0, 1'b1, 'h100, 'h04, 2 + w);
        end
        wait_cfg = 2'b00;
    endtask

    task automatic t_write;
        run("R9 int write", 1'b1, 1'b1, 16'h0321, 8'hA5, 1'b1, 'h321, 'h04, 2);
        run("R9 ext write", 1'b1, 1'b1, 16'h9876, 8'h3C, 1'b0, 'h76, 'h98, 2);
        run("R9 read no we", 1'b0, 1'b1, 16'h0321, 8'h11, 1'b1, 'h321, 'h98, 2);
    endtask

    // Page write coinciding with a strobe, and another during the access.
    task automatic t_page_race;
        int n = 1;
        set_page(8'h02);
        wait_cfg = 2'b11;
        @(negedge clk);
        page_we = 1'b1; page_wdata = 8'h05;
        acc_rd = 1'b1; acc_wide = 1'b0; acc_addr = 16'h0010;
        @(negedge clk);
        page_we = 1'b0; acc_rd = 1'b0;
        while (!done && n < 20) begin
            if (n == 2) begin page_we = 1'b1; page_wdata = 8'h06; end
            else page_we = 1'b0;
            chk("R10 addr held", int'(ram_addr), 'h210);
            @(negedge clk);
            n++;
        end
        page_we = 1'b0;
        chk("R10 old page used", int'(ram_addr), 'h210);
        chk("R10 cycles R8", n, 5);
        wait_cfg = 2'b00;
        run("R10 new page", 1'b0, 1'b0, 16'h0010, 8'h0, 1'b1, 'h610, 'h98, 2);
    endtask

    task automatic t_busy_strobe;
        int n = 1;
        wait_cfg = 2'b11;
        @(negedge clk);
        acc_rd = 1'b1; acc_wide = 1'b1; acc_addr = 16'h0100;
        @(negedge clk);
        acc_rd = 1'b0;
        while (!done && n < 20) begin
            if (n == 2) begin acc_wr = 1'b1; acc_addr = 16'hF700; end
            else acc_wr = 1'b0;
            @(negedge clk);
            n++;
        end
        acc_wr = 1'b0;
        chk("R11 cycles", n, 5);
        chk("R11 addr kept", int'(ram_addr), 'h100);
        chk("R11 no write", int'(ram_we), 0);
        @(negedge clk);
        chk("R11 no second access", int'(stall | done | ram_en | ext_req), 0);
        chk("R11 hi untouched", int'(ext_addr_hi), 'h98);
        wait_cfg = 2'b00;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_wide();
        t_size();
        t_ctrl();
        t_wait();
        t_write();
        t_page_race();
        t_busy_strobe();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule